// File: doc/BRIEF.md
# Encoded-Weight Round-Robin Arbiter

This block shares one resource among a set of requesting clients. Each client carries a 3-bit weight code that bounds how many back-to-back grants it may take once it holds the turn. Clients are split into four equal groups by index (client i belongs to group i / (clients per group)). When a turn ends, a group is chosen first and then a client inside that group.

One configuration bit picks how the group is chosen. In fair mode the groups rotate in circular order. In strict mode the requesting group with the highest 2-bit priority wins. Inside a group, clients always rotate in circular order. Only the first three group priorities are inputs. The fourth is derived so that the four priorities together form the set 0..3. The grant is one-hot and combinational from the requests and the arbiter state. The state advances on the rising clock edge.

Top module: `wrr_arbiter`

## Requirements
- R1: `gnt_o` has at most one bit set. It is nonzero in every cycle where any request is high and reset is not active.
- R2: A grant bit is set only when the matching request bit is high in the same cycle.
- R3: Client i's weight code sits in `wcode_i[3i+2:3i]`. Codes 1 to 7 allow that many consecutive grants per turn. Code 0 allows 8. A client that keeps requesting receives exactly that many grants in a row when others are also waiting.
- R4: In fair mode, from reset with all eight clients requesting and every weight code 1, the grant order is 0,2,4,6,1,3,5,7 and then repeats from 0. Groups rotate, and each group's inner pointer advances once per visit.
- R5: A turn ends at once when the holder drops its request. In that same cycle the grant passes to the next requesting client in circular order, which can be the other client of the same group.
- R6: A weight code change for the client holding the turn does not alter the current turn. It takes effect the next time that client wins a turn.
- R7: In a cycle with no requests, `gnt_o` is zero and the group and client pointers keep their values. Arbitration resumes where it left off.
- R8: With `grp_strict_i`=1, a new turn goes to the requesting group with the highest priority, where 3 is the highest and 0 the lowest. Within that group, clients still rotate.
- R9: `grp_prio_i[1:0]`, `[3:2]` and `[5:4]` are the priorities of groups 0, 1 and 2. Group 3's priority is 6 minus their sum, taken modulo 4.
- R10: While reset is active, and until it has passed through the internal synchronizer, `gnt_o` is zero whatever the requests. The first grant after reset with all clients requesting goes to client 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside |
| req_i | input | N_CLI | Per-client request |
| wcode_i | input | 3*N_CLI | Packed weight codes, client 0 in the lowest bits |
| grp_strict_i | input | 1 | Group mode: 0 fair rotation, 1 strict priority |
| grp_prio_i | input | 6 | Priorities of groups 0, 1, 2 (2 bits each) |
| gnt_o | output | N_CLI | One-hot grant |

## Verification
The strict-priority properties assume that the three programmed group priorities are distinct from each other and from the derived fourth value. Under that assumption the group ranking is a true permutation. The stimulus only programs such permutations. Weight and mode inputs are changed right after a clock edge, so any turn that begins at the next edge latches a known weight. The pointer-hold property assumes requests are stable during a cycle, and the bench keeps them so.

// File: rtl/wrr_arb_pkg.sv
package wrr_arb_pkg;
  localparam int WCODE_W = 3;
  localparam int PRIO_W  = 2;
  localparam int N_GRP   = 4;
  localparam int CNT_W   = 4;

  // code 0 is the heaviest setting (8 grants), other codes are literal
  function automatic logic [CNT_W-1:0] wcode_to_weight(input logic [WCODE_W-1:0] code);
    if (code == '0) return CNT_W'(8);
    return CNT_W'(code);
  endfunction
endpackage

// File: rtl/wrr_rr_pick.sv
module wrr_rr_pick #(
  parameter int W  = 2,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req,
  input  logic [IW-1:0] last,
  output logic          found,
  output logic [IW-1:0] idx
);
  // first requester strictly after 'last', wrapping around
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = W; k >= 1; k--) begin
      if (req[(int'(last) + k) % W]) begin
        found = 1'b1;
        idx   = IW'((int'(last) + k) % W);
      end
    end
  end
endmodule

// File: rtl/wrr_group_sel.sv
module wrr_group_sel
  import wrr_arb_pkg::*;
#(
  parameter int NG = N_GRP,
  parameter int PW = PRIO_W,
  localparam int GIW = (NG > 1) ? $clog2(NG) : 1,
  localparam int PRIO_TOTAL = NG * (NG - 1) / 2
) (
  input  logic [NG-1:0]        greq,
  input  logic [GIW-1:0]       grp_last,
  input  logic                 strict,
  input  logic [(NG-1)*PW-1:0] prio_lo,
  output logic                 found,
  output logic [GIW-1:0]       gidx
);
  logic           rr_found;
  logic [GIW-1:0] rr_idx;
  logic           sp_found;
  logic [GIW-1:0] sp_idx;
  logic [PW-1:0]  pr [NG];
  logic [PW-1:0]  best;

  wrr_rr_pick #(.W(NG)) u_grp_rr (
    .req   (greq),
    .last  (grp_last),
    .found (rr_found),
    .idx   (rr_idx)
  );

  // priorities: programmed ones plus the derived remainder for the last group
  always_comb begin
    int sum;
    sum = 0;
    for (int g = 0; g < NG - 1; g++) begin
      pr[g] = prio_lo[g*PW +: PW];
      sum   = sum + int'(prio_lo[g*PW +: PW]);
    end
    pr[NG-1] = PW'(PRIO_TOTAL - sum);
  end

  // highest priority wins; equal values resolve toward the lower index
  always_comb begin
    sp_found = 1'b0;
    sp_idx   = '0;
    best     = '0;
    for (int g = NG - 1; g >= 0; g--) begin
      if (greq[g] && (!sp_found || pr[g] >= best)) begin
        sp_found = 1'b1;
        sp_idx   = GIW'(g);
        best     = pr[g];
      end
    end
  end

  assign found = strict ? sp_found : rr_found;
  assign gidx  = strict ? sp_idx   : rr_idx;
endmodule

// File: rtl/wrr_rst_sync.sv
module wrr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/wrr_arbiter.sv
module wrr_arbiter
  import wrr_arb_pkg::*;
#(
  parameter int N_CLI = 8,
  localparam int CPG = N_CLI / N_GRP,
  localparam int CIW = (CPG > 1) ? $clog2(CPG) : 1,
  localparam int GIW = $clog2(N_GRP),
  localparam int HIW = (N_CLI > 1) ? $clog2(N_CLI) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_CLI-1:0]            req_i,
  input  logic [WCODE_W*N_CLI-1:0]    wcode_i,
  input  logic                        grp_strict_i,
  input  logic [(N_GRP-1)*PRIO_W-1:0] grp_prio_i,
  output logic [N_CLI-1:0]            gnt_o
);
  logic rst_sync_n;

  // turn state
  logic [HIW-1:0]   holder_q,   holder_d;
  logic             hold_vld_q, hold_vld_d;
  logic [CNT_W-1:0] used_q,     used_d;
  logic [CNT_W-1:0] wlat_q,     wlat_d;
  logic [GIW-1:0]   grp_last_q, grp_last_d;
  logic [CIW-1:0]   lptr_q [N_GRP];
  logic [CIW-1:0]   lptr_d [N_GRP];
  logic             st_en;

  // selection
  logic [N_GRP-1:0] lfound;
  logic [CIW-1:0]   lidx [N_GRP];
  logic             gfound;
  logic [GIW-1:0]   gsel;
  logic [HIW-1:0]   winner;
  logic             keep;
  logic             new_turn;

  wrr_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    wrr_rr_pick #(.W(CPG)) u_cli_rr (
      .req   (req_i[g*CPG +: CPG]),
      .last  (lptr_q[g]),
      .found (lfound[g]),
      .idx   (lidx[g])
    );
  end

  wrr_group_sel #(.NG(N_GRP), .PW(PRIO_W)) u_grp_sel (
    .greq     (lfound),
    .grp_last (grp_last_q),
    .strict   (grp_strict_i),
    .prio_lo  (grp_prio_i),
    .found    (gfound),
    .gidx     (gsel)
  );

  assign winner   = HIW'(int'(gsel) * CPG + int'(lidx[gsel]));
  assign keep     = hold_vld_q && req_i[holder_q] && (used_q < wlat_q);
  assign new_turn = !keep && gfound;

  always_comb begin
    gnt_o = '0;
    if (rst_sync_n) begin
      if (keep)          gnt_o[holder_q] = 1'b1;
      else if (new_turn) gnt_o[winner]   = 1'b1;
    end
  end

  // next state
  always_comb begin
    holder_d   = holder_q;
    hold_vld_d = hold_vld_q;
    used_d     = used_q;
    wlat_d     = wlat_q;
    grp_last_d = grp_last_q;
    for (int g = 0; g < N_GRP; g++) lptr_d[g] = lptr_q[g];
    if (keep) begin
      used_d = used_q + CNT_W'(1);
    end else if (new_turn) begin
      holder_d     = winner;
      hold_vld_d   = 1'b1;
      used_d       = CNT_W'(1);
      wlat_d       = wcode_to_weight(wcode_i[int'(winner)*WCODE_W +: WCODE_W]);
      grp_last_d   = gsel;
      lptr_d[gsel] = lidx[gsel];
    end else begin
      hold_vld_d = 1'b0;
    end
  end

  assign st_en = keep || new_turn || hold_vld_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      holder_q   <= '0;
      hold_vld_q <= 1'b0;
      used_q     <= '0;
      wlat_q     <= '0;
      grp_last_q <= GIW'(N_GRP - 1);
      for (int g = 0; g < N_GRP; g++) lptr_q[g] <= CIW'(CPG - 1);
    end else if (st_en) begin
      holder_q   <= holder_d;
      hold_vld_q <= hold_vld_d;
      used_q     <= used_d;
      wlat_q     <= wlat_d;
      grp_last_q <= grp_last_d;
      for (int g = 0; g < N_GRP; g++) lptr_q[g] <= lptr_d[g];
    end
  end
endmodule

// File: rtl/wrr_arbiter_chk.sv
module wrr_arbiter_chk #(
  parameter int N   = 8,
  parameter int GIW = 2,
  parameter int CW  = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [N-1:0]   req,
  input logic [N-1:0]   gnt,
  input logic [GIW-1:0] grp_last,
  input logic [CW-1:0]  used,
  input logic [CW-1:0]  wlat
);
  // R1
  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
  // R1
  a_r1_grant_when_req: assert property (@(posedge clk) disable iff (!rst_n) (|req) |-> (|gnt));
  // R2
  a_r2_only_requesters: assert property (@(posedge clk) disable iff (!rst_n) (gnt & ~req) == '0);
  // R7
  a_r7_idle_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n) (req == '0) |=> $stable(grp_last));
  // R3
  a_r3_run_within_weight: assert property (@(posedge clk) disable iff (!rst_n) used <= wlat);
endmodule

bind wrr_arbiter wrr_arbiter_chk #(.N(N_CLI), .GIW(GIW), .CW(wrr_arb_pkg::CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .req      (req_i),
  .gnt      (gnt_o),
  .grp_last (grp_last_q),
  .used     (used_q),
  .wlat     (wlat_q)
);

// File: tb/tb_wrr_arbiter.sv
module tb_wrr_arbiter;
  localparam int N = 8;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  req;
  logic [3*N-1:0] wcode;
  logic          strict;
  logic [5:0]    prio;
  logic [N-1:0]  gnt;

  // values applied just after the next rising edge
  logic [3*N-1:0] nx_wcode;
  logic           nx_strict;
  logic [5:0]     nx_prio;

  typedef struct {
    logic [N-1:0] exp;
    string        tag;
  } item_t;
  item_t sb_q[$];

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  wrr_arbiter #(.N_CLI(N)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req),
    .wcode_i      (wcode),
    .grp_strict_i (strict),
    .grp_prio_i   (prio),
    .gnt_o        (gnt)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic compare(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: gnt=%h expected %h", tag, act, exp);
    end
  endtask

  // driver: apply inputs after the edge, queue the expected grant
  task automatic step(input logic [N-1:0] r, input logic [N-1:0] exp, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    req    = r;
    wcode  = nx_wcode;
    strict = nx_strict;
    prio   = nx_prio;
    it.exp = exp;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      compare(gnt, it.exp, it.tag);
    end
  end

  task automatic do_reset(input bit check_r10);
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    req   = '1;
    @(negedge clk);
    if (check_r10) compare(gnt, '0, "R10 reset gnt");
    @(posedge clk);
    #1;
    req   = '0;
    rst_n = 1'b1;
    @(negedge clk);
    if (check_r10) compare(gnt, '0, "R10 sync gnt");
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: done=0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    req       = '0;
    wcode     = {N{3'd1}};
    strict    = 1'b0;
    prio      = '0;
    nx_wcode  = {N{3'd1}};
    nx_strict = 1'b0;
    nx_prio   = '0;

    // R10, R4, R1: fair rotation from reset
    do_reset(1'b1);
    step(8'hFF, 8'h01, "R10 first grant");
    step(8'hFF, 8'h04, "R4 order");
    step(8'hFF, 8'h10, "R4 order");
    step(8'hFF, 8'h40, "R4 order");
    step(8'hFF, 8'h02, "R4 order");
    step(8'hFF, 8'h08, "R4 order");
    step(8'hFF, 8'h20, "R4 order");
    step(8'hFF, 8'h80, "R4 order");
    step(8'hFF, 8'h01, "R4 wrap");

    // R3: code 3 gives three grants, code 0 gives eight
    nx_wcode = {N{3'd1}};
    nx_wcode[2:0] = 3'd3;
    nx_wcode[8:6] = 3'd0;
    do_reset(1'b0);
    for (int i = 0; i < 3; i++) step(8'h05, 8'h01, "R3 weight 3");
    for (int i = 0; i < 8; i++) step(8'h05, 8'h04, "R3 code 0 weight 8");
    for (int i = 0; i < 3; i++) step(8'h05, 8'h01, "R3 weight 3 again");

    // R5: holder drops request
    nx_wcode = {N{3'd0}};
    do_reset(1'b0);
    step(8'h03, 8'h01, "R5 start");
    step(8'h03, 8'h01, "R5 hold");
    step(8'h02, 8'h02, "R5 drop passes turn");
    step(8'h03, 8'h02, "R5 new holder keeps");

    // R6: weight change mid-turn
    nx_wcode = {N{3'd1}};
    nx_wcode[2:0] = 3'd2;
    do_reset(1'b0);
    step(8'h05, 8'h01, "R6 turn start");
    nx_wcode[2:0] = 3'd4;
    step(8'h05, 8'h01, "R6 old weight");
    step(8'h05, 8'h04, "R6 turn ends at old weight");
    for (int i = 0; i < 4; i++) step(8'h05, 8'h01, "R6 new weight");
    step(8'h05, 8'h04, "R6 after new weight");

    // R7: idle keeps pointers
    nx_wcode = {N{3'd1}};
    do_reset(1'b0);
    step(8'hFF, 8'h01, "R7 before idle");
    for (int i = 0; i < 3; i++) step(8'h00, 8'h00, "R7 idle no grant");
    step(8'hFF, 8'h04, "R7 resume");

    // R8, R9: strict group priority
    nx_strict = 1'b1;
    nx_prio   = 6'b00_10_01;  // g0=1 g1=2 g2=0, so g3=3
    do_reset(1'b0);
    for (int i = 0; i < 3; i++) step(8'h55, 8'h40, "R9 derived top group");
    step(8'h15, 8'h04, "R8 next highest group");
    nx_prio = 6'b01_10_11;    // g0=3 g1=2 g2=1, so g3=0
    step(8'h55, 8'h01, "R8 group 0 highest");
    step(8'h03, 8'h02, "R8 rotate inside group");
    step(8'h03, 8'h01, "R8 rotate inside group");
    step(8'h40, 8'h40, "R9 lowest group alone");

    @(posedge clk);
    @(negedge clk);
    #1;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule